// File: doc/BRIEF.md
# Bus Master Error Capture Unit

This block sits between a DMA engine and the master side of a host bus. It forwards accepted DMA requests to the bus logic. It turns away any request made while mastering is switched off, and it keeps a sticky record of every failure it sees. Failures fall into two classes. Bus protocol errors are a target abort, a master abort and a reported data parity error; software can clear them. Internal failures are a request made with mastering disabled, or a loss of synchronisation on the DMA path; only a reset can clear them, and they are mirrored into a two-bit system status word.

A summary error bit is set by any failure and drives a level interrupt, gated by an enable input. On the first failure after the summary bit was last clear, the unit stores the failing address and the transfer direction. The address goes into a read-fault field or a write-fault field, so the host can later find out what went wrong. A local processor can wipe the protocol errors with a one-cycle clear control bit. The active-low hard reset clears every flag and capture. The global reset does the same asynchronously.

The request path is a four-state machine:
- `ST_IDLE` is ready for a request.
  - A request with mastering on goes to `ST_LAUNCH`.
  - A request with mastering off goes to `ST_REJECT`.
- `ST_LAUNCH` issues a one-cycle start toward the bus logic, then always goes to `ST_WAIT`.
- `ST_WAIT` waits for the termination report, then returns to `ST_IDLE` once the report arrives.
- `ST_REJECT` returns a one-cycle error response to the DMA, then always goes to `ST_IDLE`.

The hard reset forces the machine back to `ST_IDLE`.

Top module: `bmerr_unit`

## Requirements
- R1: A request seen in idle with `mst_en`=1 gives `bus_start`=1 for exactly the next cycle, with `bus_addr`/`bus_wr` equal to the request. `dma_req_rdy` stays 0 from then until the cycle after `bus_done`.
- R2: A request seen in idle with `mst_en`=0 never raises `bus_start`. It gives `dma_err_rsp`=1 for exactly the next cycle and sets the summary bit, the interface-disabled flag and `sys_stat[1]`.
- R3: A `sync_loss` strobe sets the summary bit, the internal-failure flag and `sys_stat[0]` on the next cycle.
- R4: A `bus_done` report sets the sticky flag for each asserted termination (target abort, master abort, parity) and the summary bit. `err_stat` layout: bit0 summary, bit1 target abort, bit2 master abort, bit3 parity, bit4 interface disabled, bit5 internal failure.
- R5: A host write (`host_wr_en`) clears each of bits 1..3 whose data bit is 1 and leaves the others unchanged.
- R6: Writing ones to bits 4 and 5 has no effect. Those flags clear only on hard or global reset.
- R7: Writing 1 to bit0 clears the summary bit. `irq` equals summary bit AND `irq_en`.
- R8: A `lp_clr_req` pulse makes `err_rst_ctl` 1 for one cycle. In the following cycle bits 0..3 read 0, while bits 4 and 5 stay set.
- R9: On a capturing failure, the address goes into `fault_rd_addr` (read, `dma_req_wr`=0) or `fault_wr_addr` (write). `fault_is_rd` records the direction.
- R10: Capture happens only when the summary bit was clear. Later failures leave the address fields and the direction unchanged.
- R11: When a set and a write-one clear hit the same flag in one cycle, the flag ends up set.
- R12: `hard_rst_n`=0 at a clock edge clears all flags, the status word, the captures and the clear control bit.
- R13: After global reset, all flags, captures and `irq` are 0, and `dma_req_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, asynchronous, active low |
| hard_rst_n | input | 1 | Hard reset, synchronous, active low |
| mst_en | input | 1 | Bus mastering enable |
| irq_en | input | 1 | Interrupt enable |
| dma_req_vld | input | 1 | DMA request valid |
| dma_req_wr | input | 1 | Request direction, 1 = write |
| dma_req_addr | input | AW | Request address |
| dma_req_rdy | output | 1 | Ready for a request |
| dma_err_rsp | output | 1 | One-cycle rejection response |
| bus_start | output | 1 | One-cycle transaction start to bus logic |
| bus_wr | output | 1 | Direction of launched transaction |
| bus_addr | output | AW | Address of launched transaction |
| bus_done | input | 1 | Transaction termination report valid |
| bus_tabort | input | 1 | Target abort received |
| bus_mabort | input | 1 | Master abort received |
| bus_perr | input | 1 | Data parity error reported |
| sync_loss | input | 1 | DMA synchronisation loss strobe |
| host_wr_en | input | 1 | Host write strobe for status register |
| host_wr_data | input | 6 | Write-one-to-clear data |
| lp_clr_req | input | 1 | Local processor error clear request |
| err_rst_ctl | output | 1 | Error clear control bit (self clearing) |
| err_stat | output | 6 | Sticky status flags |
| sys_stat | output | 2 | System status: [1] interface disabled, [0] internal failure |
| irq | output | 1 | Bus error interrupt level |
| fault_rd_addr | output | AW | Captured read fault address |
| fault_wr_addr | output | AW | Captured write fault address |
| fault_is_rd | output | 1 | Captured direction, 1 = read |

## Verification
A wrong machine state shows up within one cycle: a missing or doubled `bus_start`, a rejection that lacks `dma_err_rsp`, or `dma_req_rdy` reading wrong. A flag register that mis-handles its clear rule appears in `err_stat` on the cycle after the offending write, pulse or event. So each clear source is followed by an immediate readback. Capture faults are visible only through the address fields and the direction bit. For that reason the bench drives a second failure while the summary bit is still set, and then a third after clearing it, so that any overwrite or stale hold is seen.

// File: rtl/bmerr_pkg.sv
package bmerr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_REJECT = 2'd3
    } req_state_e;

    localparam int STAT_W    = 6;
    localparam int BIT_MERR  = 0;
    localparam int BIT_TAB   = 1;
    localparam int BIT_MAB   = 2;
    localparam int BIT_PERR  = 3;
    localparam int BIT_IFDIS = 4;
    localparam int BIT_INTF  = 5;

    // bits that software may clear (summary plus protocol class)
    localparam logic [STAT_W-1:0] SW_CLR_MASK = 6'b001111;

    typedef struct packed {
        logic tab;
        logic mab;
        logic perr;
        logic ifdis;
        logic intf;
    } err_evt_t;
endpackage

// File: rtl/bmerr_req_fsm.sv
module bmerr_req_fsm
    import bmerr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hard_rst_n,
    input  logic          mst_en,
    input  logic          req_vld,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    output logic          req_rdy,
    output logic          dma_err_rsp,
    output logic          bus_start,
    output logic          bus_wr,
    output logic [AW-1:0] bus_addr,
    input  logic          bus_done,
    input  logic          bus_tabort,
    input  logic          bus_mabort,
    input  logic          bus_perr,
    input  logic          sync_loss,
    output err_evt_t      evt,
    output logic          evt_wr,
    output logic [AW-1:0] evt_addr
);
    req_state_e    state_q, state_d;
    logic          hold_wr;
    logic [AW-1:0] hold_addr;
    logic          take;

    assign take = (state_q == ST_IDLE) && req_vld;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hold_wr   <= 1'b0;
            hold_addr <= '0;
        end else if (!hard_rst_n) begin
            state_q   <= ST_IDLE;
            hold_wr   <= 1'b0;
            hold_addr <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                hold_wr   <= req_wr;
                hold_addr <= req_addr;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_vld) state_d = mst_en ? ST_LAUNCH : ST_REJECT;
            end
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (bus_done) state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_rdy     = 1'b0;
        bus_start   = 1'b0;
        dma_err_rsp = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_rdy     = 1'b1;
            ST_LAUNCH: bus_start   = 1'b1;
            ST_WAIT:   ;
            ST_REJECT: dma_err_rsp = 1'b1;
            default:   ;
        endcase
    end

    assign bus_wr   = hold_wr;
    assign bus_addr = hold_addr;

    always_comb begin
        evt.ifdis = take && !mst_en;
        evt.tab   = (state_q == ST_WAIT) && bus_done && bus_tabort;
        evt.mab   = (state_q == ST_WAIT) && bus_done && bus_mabort;
        evt.perr  = (state_q == ST_WAIT) && bus_done && bus_perr;
        evt.intf  = sync_loss;
        evt_wr    = evt.ifdis ? req_wr   : hold_wr;
        evt_addr  = evt.ifdis ? req_addr : hold_addr;
    end

    AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_vld && !mst_en && hard_rst_n) |=> (dma_err_rsp && !bus_start)); // R2
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !bus_start); // R1
endmodule

// File: rtl/bmerr_flags.sv
module bmerr_flags
    import bmerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_rst_n,
    input  err_evt_t          evt,
    input  logic              w1c_en,
    input  logic [STAT_W-1:0] w1c_data,
    input  logic              lp_clr_req,
    output logic [STAT_W-1:0] stat,
    output logic              clr_ctl,
    output logic              cap_stb
);
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic              any_evt;
    logic              clr_pend;

    assign any_evt = evt.tab | evt.mab | evt.perr | evt.ifdis | evt.intf;

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_MERR]  = any_evt;
        set_vec[BIT_TAB]   = evt.tab;
        set_vec[BIT_MAB]   = evt.mab;
        set_vec[BIT_PERR]  = evt.perr;
        set_vec[BIT_IFDIS] = evt.ifdis;
        set_vec[BIT_INTF]  = evt.intf;
        clr_vec = (({STAT_W{w1c_en}} & w1c_data) | {STAT_W{clr_pend}}) & SW_CLR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q   <= '0;
            clr_pend <= 1'b0;
        end else if (!hard_rst_n) begin
            stat_q   <= '0;
            clr_pend <= 1'b0;
        end else begin
            stat_q   <= set_vec | (stat_q & ~clr_vec);
            clr_pend <= lp_clr_req;
        end
    end

    assign stat    = stat_q;
    assign clr_ctl = clr_pend;
    assign cap_stb = any_evt && !stat_q[BIT_MERR];

    AST_INTF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_INTF] && hard_rst_n) |=> stat_q[BIT_INTF]); // R6
    AST_IFDIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_IFDIS] && hard_rst_n) |=> stat_q[BIT_IFDIS]); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.tab && hard_rst_n) |=> (stat_q[BIT_TAB] && stat_q[BIT_MERR])); // R11
endmodule

// File: rtl/bmerr_capture.sv
module bmerr_capture #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hard_rst_n,
    input  logic          cap_stb,
    input  logic          cap_wr,
    input  logic [AW-1:0] cap_addr,
    input  logic          merr,
    output logic [AW-1:0] rd_addr,
    output logic [AW-1:0] wr_addr,
    output logic          is_rd
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr <= '0;
            wr_addr <= '0;
            is_rd   <= 1'b0;
        end else if (!hard_rst_n) begin
            rd_addr <= '0;
            wr_addr <= '0;
            is_rd   <= 1'b0;
        end else if (cap_stb) begin
            is_rd <= !cap_wr;
            if (cap_wr) wr_addr <= cap_addr;
            else        rd_addr <= cap_addr;
        end
    end

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (merr && hard_rst_n) |=> ($stable(rd_addr) && $stable(wr_addr) && $stable(is_rd))); // R10
endmodule

// File: rtl/bmerr_unit.sv
module bmerr_unit
    import bmerr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_rst_n,
    input  logic              mst_en,
    input  logic              irq_en,
    input  logic              dma_req_vld,
    input  logic              dma_req_wr,
    input  logic [AW-1:0]     dma_req_addr,
    output logic              dma_req_rdy,
    output logic              dma_err_rsp,
    output logic              bus_start,
    output logic              bus_wr,
    output logic [AW-1:0]     bus_addr,
    input  logic              bus_done,
    input  logic              bus_tabort,
    input  logic              bus_mabort,
    input  logic              bus_perr,
    input  logic              sync_loss,
    input  logic              host_wr_en,
    input  logic [STAT_W-1:0] host_wr_data,
    input  logic              lp_clr_req,
    output logic              err_rst_ctl,
    output logic [STAT_W-1:0] err_stat,
    output logic [1:0]        sys_stat,
    output logic              irq,
    output logic [AW-1:0]     fault_rd_addr,
    output logic [AW-1:0]     fault_wr_addr,
    output logic              fault_is_rd
);
    err_evt_t      evt;
    logic          evt_wr;
    logic [AW-1:0] evt_addr;
    logic          cap_stb;

    bmerr_req_fsm #(.AW(AW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hard_rst_n  (hard_rst_n),
        .mst_en      (mst_en),
        .req_vld     (dma_req_vld),
        .req_wr      (dma_req_wr),
        .req_addr    (dma_req_addr),
        .req_rdy     (dma_req_rdy),
        .dma_err_rsp (dma_err_rsp),
        .bus_start   (bus_start),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_done    (bus_done),
        .bus_tabort  (bus_tabort),
        .bus_mabort  (bus_mabort),
        .bus_perr    (bus_perr),
        .sync_loss   (sync_loss),
        .evt         (evt),
        .evt_wr      (evt_wr),
        .evt_addr    (evt_addr)
    );

    bmerr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .hard_rst_n (hard_rst_n),
        .evt        (evt),
        .w1c_en     (host_wr_en),
        .w1c_data   (host_wr_data),
        .lp_clr_req (lp_clr_req),
        .stat       (err_stat),
        .clr_ctl    (err_rst_ctl),
        .cap_stb    (cap_stb)
    );

    bmerr_capture #(.AW(AW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .hard_rst_n (hard_rst_n),
        .cap_stb    (cap_stb),
        .cap_wr     (evt_wr),
        .cap_addr   (evt_addr),
        .merr       (err_stat[BIT_MERR]),
        .rd_addr    (fault_rd_addr),
        .wr_addr    (fault_wr_addr),
        .is_rd      (fault_is_rd)
    );

    assign sys_stat = {err_stat[BIT_IFDIS], err_stat[BIT_INTF]};
    assign irq      = err_stat[BIT_MERR] & irq_en;

    AST_SYNC_TO_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_loss && hard_rst_n) |=> (sys_stat[0] && err_stat[BIT_MERR])); // R3
endmodule

// File: tb/sim_bmerr_unit.sv
`timescale 1ns/1ps
module sim_bmerr_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hard_rst_n = 1'b1;
    logic          mst_en = 1'b1;
    logic          irq_en = 1'b0;
    logic          dma_req_vld = 1'b0;
    logic          dma_req_wr = 1'b0;
    logic [AW-1:0] dma_req_addr = '0;
    logic          dma_req_rdy, dma_err_rsp, bus_start, bus_wr;
    logic [AW-1:0] bus_addr;
    logic          bus_done = 1'b0, bus_tabort = 1'b0, bus_mabort = 1'b0, bus_perr = 1'b0;
    logic          sync_loss = 1'b0;
    logic          host_wr_en = 1'b0;
    logic [5:0]    host_wr_data = '0;
    logic          lp_clr_req = 1'b0;
    logic          err_rst_ctl;
    logic [5:0]    err_stat;
    logic [1:0]    sys_stat;
    logic          irq;
    logic [AW-1:0] fault_rd_addr, fault_wr_addr;
    logic          fault_is_rd;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bmerr_unit #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .hard_rst_n(hard_rst_n), .mst_en(mst_en), .irq_en(irq_en),
        .dma_req_vld(dma_req_vld), .dma_req_wr(dma_req_wr), .dma_req_addr(dma_req_addr),
        .dma_req_rdy(dma_req_rdy), .dma_err_rsp(dma_err_rsp), .bus_start(bus_start),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_done(bus_done), .bus_tabort(bus_tabort),
        .bus_mabort(bus_mabort), .bus_perr(bus_perr), .sync_loss(sync_loss),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data), .lp_clr_req(lp_clr_req),
        .err_rst_ctl(err_rst_ctl), .err_stat(err_stat), .sys_stat(sys_stat), .irq(irq),
        .fault_rd_addr(fault_rd_addr), .fault_wr_addr(fault_wr_addr), .fault_is_rd(fault_is_rd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // full enabled transaction; term = {perr, mab, tab}
    task automatic do_xact(input logic wr, input logic [AW-1:0] a, input logic [2:0] term);
        @(negedge clk); dma_req_vld = 1'b1; dma_req_wr = wr; dma_req_addr = a; mst_en = 1'b1;
        @(negedge clk); dma_req_vld = 1'b0;
        @(negedge clk); bus_done = 1'b1; {bus_perr, bus_mabort, bus_tabort} = term;
        @(negedge clk); bus_done = 1'b0; {bus_perr, bus_mabort, bus_tabort} = 3'b000;
    endtask

    task automatic do_reject(input logic wr, input logic [AW-1:0] a);
        @(negedge clk); dma_req_vld = 1'b1; dma_req_wr = wr; dma_req_addr = a; mst_en = 1'b0;
        @(negedge clk); dma_req_vld = 1'b0; mst_en = 1'b1;
    endtask

    task automatic do_sync();
        @(negedge clk); sync_loss = 1'b1;
        @(negedge clk); sync_loss = 1'b0;
    endtask

    task automatic do_w1c(input logic [5:0] d);
        @(negedge clk); host_wr_en = 1'b1; host_wr_data = d;
        @(negedge clk); host_wr_en = 1'b0; host_wr_data = '0;
    endtask

    task automatic do_lpclr();
        @(negedge clk); lp_clr_req = 1'b1;
        @(negedge clk); lp_clr_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_hrst();
        @(negedge clk); hard_rst_n = 1'b0;
        @(negedge clk); hard_rst_n = 1'b1;
    endtask

    // {op[2:0], arg[7:0], expected err_stat[5:0]}
    // op 0 xact (arg[0]=wr, arg[3:1]={perr,mab,tab}), 1 reject, 2 sync loss,
    // 3 host write-one-clear (arg[5:0]), 4 local clear, 5 hard reset
    localparam int NV = 14;
    localparam logic [16:0] VEC [NV] = '{
        {3'd0, 8'h00, 6'h00},  // R1 clean transfer
        {3'd0, 8'h02, 6'h03},  // R4 target abort
        {3'd3, 8'h02, 6'h01},  // R5 clear target abort only
        {3'd0, 8'h04, 6'h05},  // R4 master abort
        {3'd0, 8'h09, 6'h0D},  // R4 parity on write
        {3'd3, 8'h0C, 6'h01},  // R5
        {3'd3, 8'h01, 6'h00},  // R7 clear summary
        {3'd1, 8'h00, 6'h11},  // R2 reject
        {3'd3, 8'h3F, 6'h10},  // R6 ifdis survives write-one
        {3'd2, 8'h00, 6'h31},  // R3 sync loss
        {3'd4, 8'h00, 6'h30},  // R8 local clear keeps internal flags
        {3'd0, 8'h02, 6'h33},  // R4
        {3'd4, 8'h00, 6'h30},  // R8
        {3'd5, 8'h00, 6'h00}   // R12 hard reset
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 stat", {26'd0, err_stat}, 32'h0);
        chk("R13 rdy", {31'd0, dma_req_rdy}, 32'h1);
        chk("R13 irq", {31'd0, irq}, 32'h0);
        chk("R13 fault_rd", fault_rd_addr, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [7:0] arg;
            logic [5:0] exp;
            {op, arg, exp} = VEC[i];
            unique case (op)
                3'd0: do_xact(arg[0], 32'h100 + i, arg[3:1]);
                3'd1: do_reject(arg[0], 32'h100 + i);
                3'd2: do_sync();
                3'd3: do_w1c(arg[5:0]);
                3'd4: do_lpclr();
                default: do_hrst();
            endcase
            chk($sformatf("table vec %0d stat (R2 R3 R4 R5 R6 R8 R12)", i), {26'd0, err_stat}, {26'd0, exp});
        end
        chk("R12 sys_stat", {30'd0, sys_stat}, 32'h0);

        // R1 launch timing
        @(negedge clk); dma_req_vld = 1'b1; dma_req_wr = 1'b1; dma_req_addr = 32'h55AA;
        @(negedge clk); dma_req_vld = 1'b0;
        chk("R1 start", {31'd0, bus_start}, 32'h1);
        chk("R1 addr", bus_addr, 32'h55AA);
        chk("R1 wr", {31'd0, bus_wr}, 32'h1);
        chk("R1 rdy low", {31'd0, dma_req_rdy}, 32'h0);
        @(negedge clk);
        chk("R1 start once", {31'd0, bus_start}, 32'h0);
        chk("R1 rdy wait", {31'd0, dma_req_rdy}, 32'h0);
        bus_done = 1'b1;
        @(negedge clk); bus_done = 1'b0;
        chk("R1 rdy back", {31'd0, dma_req_rdy}, 32'h1);

        // R2 rejection response
        @(negedge clk); dma_req_vld = 1'b1; dma_req_wr = 1'b0; dma_req_addr = 32'h3C30; mst_en = 1'b0;
        @(negedge clk); dma_req_vld = 1'b0; mst_en = 1'b1;
        chk("R2 err rsp", {31'd0, dma_err_rsp}, 32'h1);
        chk("R2 no start", {31'd0, bus_start}, 32'h0);
        chk("R2 sys_stat", {30'd0, sys_stat}, 32'h2);
        chk("R9 reject rd addr", fault_rd_addr, 32'h3C30);
        @(negedge clk);
        chk("R2 err rsp once", {31'd0, dma_err_rsp}, 32'h0);
        chk("R2 no start later", {31'd0, bus_start}, 32'h0);

        // R7 interrupt gating
        irq_en = 1'b1; #1;
        chk("R7 irq on", {31'd0, irq}, 32'h1);
        irq_en = 1'b0; #1;
        chk("R7 irq gated", {31'd0, irq}, 32'h0);
        irq_en = 1'b1;
        do_w1c(6'h01);
        chk("R7 irq cleared", {31'd0, irq}, 32'h0);

        // R12 hard reset clears internal flags and captures
        do_hrst();
        chk("R12 stat", {26'd0, err_stat}, 32'h0);
        chk("R12 fault_rd", fault_rd_addr, 32'h0);

        // R9 / R10 capture
        do_xact(1'b0, 32'h1A10, 3'b001);
        chk("R9 rd addr", fault_rd_addr, 32'h1A10);
        chk("R9 is_rd", {31'd0, fault_is_rd}, 32'h1);
        do_xact(1'b1, 32'h2B20, 3'b010);
        chk("R10 wr addr held", fault_wr_addr, 32'h0);
        chk("R10 dir held", {31'd0, fault_is_rd}, 32'h1);
        do_w1c(6'h3F);
        do_xact(1'b1, 32'h2B20, 3'b010);
        chk("R9 wr addr", fault_wr_addr, 32'h2B20);
        chk("R9 is_wr", {31'd0, fault_is_rd}, 32'h0);
        chk("R9 rd addr kept", fault_rd_addr, 32'h1A10);
        do_w1c(6'h3F);

        // R11 set beats write-one clear
        @(negedge clk); dma_req_vld = 1'b1; dma_req_wr = 1'b0; dma_req_addr = 32'h77;
        @(negedge clk); dma_req_vld = 1'b0;
        @(negedge clk); bus_done = 1'b1; bus_tabort = 1'b1; host_wr_en = 1'b1; host_wr_data = 6'h03;
        @(negedge clk); bus_done = 1'b0; bus_tabort = 1'b0; host_wr_en = 1'b0; host_wr_data = '0;
        chk("R11 set wins", {26'd0, err_stat}, 32'h03);

        // R8 control bit timing
        @(negedge clk); lp_clr_req = 1'b1;
        @(negedge clk); lp_clr_req = 1'b0;
        chk("R8 ctl set", {31'd0, err_rst_ctl}, 32'h1);
        chk("R8 not yet", {26'd0, err_stat}, 32'h03);
        @(negedge clk);
        chk("R8 ctl self clear", {31'd0, err_rst_ctl}, 32'h0);
        chk("R8 cleared", {26'd0, err_stat}, 32'h0);

        // R6 global reset clears internal failure
        do_sync();
        chk("R3 sys_stat", {30'd0, sys_stat}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R6 global reset", {26'd0, err_stat}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule